// File: doc/BRIEF.md
# Approximate signed array multiplier

This block multiplies two 8-bit two's-complement operands and returns a 16-bit product in a single combinational pass. The partial products use a complemented-sign array: every term that pairs one sign bit with a magnitude bit is inverted, and a single correction 1 is added at weight 2^8. A two-level tree of 4:2 compressors then cuts the eight partial-product rows down to two, and an exact ripple adder finishes the sum. The design needs no conversion of operands to magnitude form and no conversion of the result back to two's complement.

The tree is split by column. The `APPROX_COLS` lowest columns use a cheap approximate compressor with no carry chain. All higher columns, including every column that can affect the sign, use exact compressors. The two top output bits do not come from the adder chain. Bit 15 is derived from the operand sign bits. Bit 14 is a three-input XOR of the two reduced row bits in column 14 and the ripple carry from column 13, so a carry can never spill into the sign position. Setting `APPROX_COLS` to 0 gives a fully exact multiplier, which serves as the reference build.

The block is meant to sit inside error-tolerant datapaths such as neural-network accumulators, where weights cluster near zero and small errors in low bits are acceptable.

Top module: `amul_signed_approx`

## Requirements
- R1: With APPROX_COLS = 0, prod equals the 16-bit two's-complement product of mul_a and mul_b for every one of the 65,536 operand pairs.
- R2: prod[15] is 1 exactly when the sign bits mul_a[7] and mul_b[7] differ and both operands are non-zero; otherwise it is 0. This holds for every APPROX_COLS.
- R3: prod[14] is the XOR of the two reduced row bits of column 14 and the carry out of column 13, with no carry from column 14 kept. With APPROX_COLS = 0 it therefore equals bit 14 of the exact product.
- R4: Let D be prod[14:0] minus bits 14..0 of the exact product, taken modulo 2^15 as a signed 15-bit value. Then |D| <= 6*(2^APPROX_COLS - 1). This is 1530 for APPROX_COLS = 8 and 90 for APPROX_COLS = 4.
- R5: When APPROX_COLS <= 7 and either operand has its APPROX_COLS lowest bits all zero, prod equals the exact product.
- R6: prod[0] equals mul_a[0] & mul_b[0] for every APPROX_COLS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mul_a | input | 8 | Multiplicand, two's complement |
| mul_b | input | 8 | Multiplier, two's complement |
| prod | output | 16 | Approximate product, two's complement |

## Verification
Every result is due in the same cycle as its operands, because no register lies between the inputs and `prod`. The bench sets the operands at a rising edge and reads all three builds (exact, four approximate columns, eight approximate columns) at the next falling edge, half a period later, when the combinational paths have settled. It walks all 65,536 operand pairs, then adds directed extremes and seeded random pairs whose low bits are often cleared, to exercise R5. For each pair it compares the outputs with products and error limits that it computes itself.

// File: rtl/amul_pkg.sv
package amul_pkg;

  // A column index below the approximation threshold uses the cheap cell.
  function automatic bit col_is_approx(input int col, input int approx_cols);
    return col < approx_cols;
  endfunction

  // Each approximate cell deviates by -2..+1 units of its column weight and
  // each column passes through three cells, so |error| <= 6 * sum(2^k).
  function automatic int err_limit(input int approx_cols);
    return 6 * ((1 << approx_cols) - 1);
  endfunction

endpackage

// File: rtl/amul_fa.sv
module amul_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);

  assign s  = x ^ y ^ z;
  assign co = (x & y) | (x & z) | (y & z);

endmodule

// File: rtl/amul_ppgen.sv
// Partial-product array with inverted sign-pair terms and the single
// correction constant at weight 2^N. Only columns 0..2N-2 are produced,
// since the top product bit is formed separately.
module amul_ppgen #(
  parameter int N = 8,
  localparam int C = 2 * N - 1
) (
  input  logic [N-1:0]        a,
  input  logic [N-1:0]        b,
  output logic [N-1:0][C-1:0] rows
);

  for (genvar j = 0; j < N; j++) begin : g_row
    for (genvar k = 0; k < C; k++) begin : g_col
      if (k >= j && k - j < N) begin : g_pp
        if ((k - j == N - 1) != (j == N - 1)) begin : g_inv
          assign rows[j][k] = ~(a[k-j] & b[j]);
        end else begin : g_pos
          assign rows[j][k] = a[k-j] & b[j];
        end
      end else if (j == 0 && k == N) begin : g_one
        assign rows[j][k] = 1'b1;
      end else begin : g_nil
        assign rows[j][k] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/amul_cmp_row.sv
// One rank of 4:2 compressors across all columns. Columns below APPROX_COLS
// use the OR/AND approximate cell without a lateral chain; the rest use two
// chained full adders. The top column keeps only its parity, since any carry
// from it would land beyond the produced range.
// cw[k] carries weight k (it is the carry of column k-1); cw[0] is zero.
module amul_cmp_row #(
  parameter int C           = 15,
  parameter int APPROX_COLS = 8,
  localparam int LO         = APPROX_COLS
) (
  input  logic [C-1:0] r0,
  input  logic [C-1:0] r1,
  input  logic [C-1:0] r2,
  input  logic [C-1:0] r3,
  output logic [C-1:0] s,
  output logic [C-1:0] cw
);

  logic [C-1:LO] cy;

  assign cw[0]  = 1'b0;
  assign cy[LO] = 1'b0;

  for (genvar k = 0; k < C; k++) begin : g_col
    if (k == C - 1) begin : g_top
      assign s[k] = r0[k] ^ r1[k] ^ r2[k] ^ r3[k] ^ cy[k];
    end else if (amul_pkg::col_is_approx(k, APPROX_COLS)) begin : g_apx
      assign s[k]    = (r0[k] | r1[k]) ^ (r2[k] | r3[k]);
      assign cw[k+1] = (r0[k] & r1[k]) | (r2[k] & r3[k]);
    end else begin : g_ex
      logic s1;
      amul_fa u_fa_lo (
        .x (r0[k]),
        .y (r1[k]),
        .z (r2[k]),
        .s (s1),
        .co(cy[k+1])
      );
      amul_fa u_fa_hi (
        .x (s1),
        .y (r3[k]),
        .z (cy[k]),
        .s (s[k]),
        .co(cw[k+1])
      );
    end
  end

endmodule

// File: rtl/amul_final_add.sv
// Carry-propagate stage over columns 0..C-2, XOR-only column C-1, and the
// sign bit taken from the operand signs.
module amul_final_add #(
  parameter int C = 15
) (
  input  logic [C-1:0] s,
  input  logic [C-1:0] c,
  input  logic         sgn_a,
  input  logic         sgn_b,
  input  logic         nz,
  output logic [C:0]   p
);

  logic [C-1:0] rc;

  assign rc[0] = 1'b0;

  for (genvar k = 0; k < C - 1; k++) begin : g_add
    amul_fa u_fa (
      .x (s[k]),
      .y (c[k]),
      .z (rc[k]),
      .s (p[k]),
      .co(rc[k+1])
    );
  end

  assign p[C-1] = s[C-1] ^ c[C-1] ^ rc[C-1];
  assign p[C]   = (sgn_a ^ sgn_b) & nz;

endmodule

// File: rtl/amul_signed_approx.sv
module amul_signed_approx #(
  parameter int N           = 8,
  parameter int APPROX_COLS = 8
) (
  input  logic [N-1:0]   mul_a,
  input  logic [N-1:0]   mul_b,
  output logic [2*N-1:0] prod
);

  localparam int W = 2 * N;
  localparam int C = W - 1;
  localparam int G = N / 2;

  logic [N-1:0][C-1:0] pp_rows;
  logic [C-1:0]        s_a, c_a, s_b, c_b;
  logic [C-1:0]        s_f, c_f;
  logic                nz;

  assign nz = (|mul_a) & (|mul_b);

  amul_ppgen #(.N(N)) u_pp (
    .a   (mul_a),
    .b   (mul_b),
    .rows(pp_rows)
  );

  amul_cmp_row #(.C(C), .APPROX_COLS(APPROX_COLS)) u_l1_lo (
    .r0(pp_rows[0]),
    .r1(pp_rows[1]),
    .r2(pp_rows[2]),
    .r3(pp_rows[3]),
    .s (s_a),
    .cw(c_a)
  );

  amul_cmp_row #(.C(C), .APPROX_COLS(APPROX_COLS)) u_l1_hi (
    .r0(pp_rows[G]),
    .r1(pp_rows[G+1]),
    .r2(pp_rows[G+2]),
    .r3(pp_rows[G+3]),
    .s (s_b),
    .cw(c_b)
  );

  amul_cmp_row #(.C(C), .APPROX_COLS(APPROX_COLS)) u_l2 (
    .r0(s_a),
    .r1(c_a),
    .r2(s_b),
    .r3(c_b),
    .s (s_f),
    .cw(c_f)
  );

  amul_final_add #(.C(C)) u_fin (
    .s    (s_f),
    .c    (c_f),
    .sgn_a(mul_a[N-1]),
    .sgn_b(mul_b[N-1]),
    .nz   (nz),
    .p    (prod)
  );

endmodule

// File: rtl/amul_signed_approx_chk.sv
module amul_signed_approx_chk #(
  parameter int N           = 8,
  parameter int APPROX_COLS = 8,
  localparam int W          = 2 * N
) (
  input logic [N-1:0] mul_a,
  input logic [N-1:0] mul_b,
  input logic [W-1:0] prod
);

  logic [W-1:0] ext_a, ext_b, ref_p;
  logic [W-2:0] diff;
  int           mag;
  logic         sign_exp;

  always_comb begin
    ext_a    = {{N{mul_a[N-1]}}, mul_a};
    ext_b    = {{N{mul_b[N-1]}}, mul_b};
    ref_p    = ext_a * ext_b;
    diff     = prod[W-2:0] - ref_p[W-2:0];
    mag      = diff[W-2] ? ((1 << (W - 1)) - int'(diff)) : int'(diff);
    sign_exp = (mul_a[N-1] ^ mul_b[N-1]) && (mul_a != '0) && (mul_b != '0);
  end

  always_comb begin
    // R2
    sign_rule_chk: assert (prod[W-1] == sign_exp);
    // R4
    err_bound_chk: assert (mag <= amul_pkg::err_limit(APPROX_COLS));
    // R6
    lsb_exact_chk: assert (prod[0] == (mul_a[0] & mul_b[0]));
  end

  if (APPROX_COLS <= N - 1) begin : g_low_exact
    localparam logic [N-1:0] LOW_MASK = N'((1 << APPROX_COLS) - 1);
    always_comb begin
      // R5 (with APPROX_COLS = 0 this is R1)
      low_zero_exact_chk: assert (!(((mul_a & LOW_MASK) == '0) ||
                                    ((mul_b & LOW_MASK) == '0)) ||
                                  (prod == ref_p));
    end
  end

  if (APPROX_COLS == 0) begin : g_exact_top
    always_comb begin
      // R3
      top_sum_bit_chk: assert (prod[W-2] == ref_p[W-2]);
    end
  end

endmodule

bind amul_signed_approx amul_signed_approx_chk #(
  .N          (N),
  .APPROX_COLS(APPROX_COLS)
) u_chk (
  .mul_a(mul_a),
  .mul_b(mul_b),
  .prod (prod)
);

// File: tb/amul_signed_approx_tb_top.sv
module amul_signed_approx_tb_top;

  logic        clk;
  logic        rst_n;
  logic [7:0]  op_a, op_b;
  logic [15:0] prod_apx, prod_ex, prod_mid;
  int          checks, errors;
  bit          done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  amul_signed_approx #(.N(8), .APPROX_COLS(8)) dut_i (
    .mul_a(op_a), .mul_b(op_b), .prod(prod_apx));
  amul_signed_approx #(.N(8), .APPROX_COLS(0)) dut_x (
    .mul_a(op_a), .mul_b(op_b), .prod(prod_ex));
  amul_signed_approx #(.N(8), .APPROX_COLS(4)) dut_m (
    .mul_a(op_a), .mul_b(op_b), .prod(prod_mid));

  function automatic logic [15:0] exp_prod(input logic [7:0] a, input logic [7:0] b);
    int va, vb;
    va = a[7] ? int'(a) - 256 : int'(a);
    vb = b[7] ? int'(b) - 256 : int'(b);
    return 16'(va * vb);
  endfunction

  function automatic int low_err(input logic [15:0] p, input logic [15:0] r);
    logic [14:0] d;
    d = p[14:0] - r[14:0];
    return d[14] ? 32768 - int'(d) : int'(d);
  endfunction

  function automatic logic exp_sign(input logic [7:0] a, input logic [7:0] b);
    return (a[7] ^ b[7]) && (a != 8'd0) && (b != 8'd0);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s a=%02h b=%02h actual=%04h expected=%04h",
               req, op_a, op_b, act, exp);
    end
  endtask

  task automatic check_all();
    logic [15:0] r;
    r = exp_prod(op_a, op_b);
    // R1: exact build matches the true product
    chk(prod_ex == r, "R1", prod_ex, r);
    // R3: bit 14 of the exact build
    chk(prod_ex[14] == r[14], "R3", {15'd0, prod_ex[14]}, {15'd0, r[14]});
    // R2: sign rule on both approximate builds
    chk(prod_apx[15] == exp_sign(op_a, op_b), "R2", {15'd0, prod_apx[15]},
        {15'd0, exp_sign(op_a, op_b)});
    chk(prod_mid[15] == exp_sign(op_a, op_b), "R2", {15'd0, prod_mid[15]},
        {15'd0, exp_sign(op_a, op_b)});
    // R4: error limits 6*(2^8-1) and 6*(2^4-1)
    chk(low_err(prod_apx, r) <= 6 * 255, "R4", prod_apx, r);
    chk(low_err(prod_mid, r) <= 6 * 15, "R4", prod_mid, r);
    // R5: low four bits of an operand clear -> four-column build is exact
    if (op_a[3:0] == 4'd0 || op_b[3:0] == 4'd0)
      chk(prod_mid == r, "R5", prod_mid, r);
    // R6: lowest bit exact in the eight-column build
    chk(prod_apx[0] == (op_a[0] & op_b[0]), "R6", {15'd0, prod_apx[0]},
        {15'd0, op_a[0] & op_b[0]});
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    op_a <= a;
    op_b <= b;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    op_a   = 8'd0;
    op_b   = 8'd0;
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    // Reset state: zero operands give zero from the exact build (R1), sign 0 (R2)
    chk(prod_ex == 16'd0, "R1", prod_ex, 16'd0);
    chk(prod_apx[15] == 1'b0, "R2", {15'd0, prod_apx[15]}, 16'd0);

    // Directed extremes
    apply(8'h80, 8'h80);
    apply(8'h80, 8'h7f);
    apply(8'h7f, 8'h7f);
    apply(8'hff, 8'hff);
    apply(8'hff, 8'h01);
    apply(8'h00, 8'h80);
    apply(8'h80, 8'h00);
    apply(8'hf0, 8'h0f);
    apply(8'h01, 8'hff);

    // Every operand pair
    for (int i = 0; i < 65536; i++) apply(8'(i >> 8), 8'(i));

    // Seeded random pairs, low nibble often cleared
    seed_v = $urandom(32'd31337);
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] ra, rb;
      logic [3:0] pick;
      ra   = 8'($urandom);
      rb   = 8'($urandom);
      pick = 4'($urandom);
      if (pick[0]) ra[3:0] = 4'd0;
      if (pick[1]) rb[3:0] = 4'd0;
      if (pick[3:2] == 2'b11) ra[6:0] = {7{ra[7]}};
      apply(ra, rb);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule